// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block sits between a synchronous host and an external asynchronous static RAM. It turns single read or write requests into correctly timed strobe sequences on the memory's active-low chip-select, write-enable and output-enable pins. It also drives the address bus and a data bus that is split into output, output-enable and input halves, so that the bidirectional pad can be placed outside the block.

Every timing limit of the memory is a nanosecond parameter. These are listed below as limit and default value:

| Limit | Default |
|---|---|
| Minimum read cycle | 8 |
| Address access | 8 |
| Output-enable access | 4 |
| Minimum write cycle | 8 |
| Select to end of write | 6 |
| Address setup | 0 |
| Address valid to end of write | 6 |
| Write pulse | 6 |
| Recovery before the memory may drive again | 3 |

Each limit is turned into whole clock cycles from a clock-period parameter, rounding up. The phase lengths of the sequence follow from those cycle counts.

The host sees a `ready` flag. It offers a request by raising `req_valid` while `ready` is high. Read data comes back on `rd_data` together with a single-cycle `rd_valid` pulse.

Top module: `sram_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rd_valid` are 0. A reset taken in the middle of a write returns all strobes high and releases the bus.
- R2: Each nanosecond limit t becomes ceil(t / CLK_PERIOD_NS) cycles; a limit of 0 needs no cycles. The read window is the largest of the read cycle, address access and output-enable access counts, and is at least 1. With a 5 ns clock the read window and the write pulse are each 2 cycles and the recovery is 1 cycle.
- R3: A read drives `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the read window. The value on `mem_dq_in` in the last cycle of the window appears on `rd_data` in the following cycle, with `rd_valid`=1. For the default 5 ns clock this is 3 cycles after the request is taken.
- R4: A write holds `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for the write pulse. `mem_addr` and `mem_dq_out` stay unchanged for the whole pulse, and the value is stored at that address.
- R5: `mem_dq_oe` is 1 only while `mem_we_n` and `mem_cs_n` are both 0.
- R6: After each write pulse, at least max(1, recovery cycles) cycles follow with all three strobes high and `mem_dq_oe`=0. `mem_oe_n` never falls in a cycle directly after one in which the bus was driven.
- R7: A write occupies at least the minimum write cycle count; with the 5 ns clock, `ready` returns 4 cycles after the request is taken. A read keeps the memory selected for at least the minimum read cycle count.
- R8: A request is taken only in a cycle where `ready` is 1, and `ready` is 0 in the cycle after it is taken. A `req_valid` raised while `ready` is 0 has no effect: it neither writes the memory nor alters the operation in progress.
- R9: `mem_we_n` and `mem_oe_n` are never 0 together. Whenever `ready` is 1 the memory is deselected (`mem_cs_n`=1) and its outputs float.
- R10: `rd_valid` is a one-cycle pulse that follows only a read window; it is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Idle and able to take a request |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data toward the memory pad |
| mem_dq_oe | output | 1 | Pad driver enable for the data bus |
| mem_dq_in | input | DATA_W | Data from the memory pad |

## Verification
Two events can fall in the same cycle: the `rd_valid` pulse that closes a read, and the acceptance of the next request, because the idle cycle that carries `rd_valid` also has `ready` high. The bench provokes this by presenting a second read in exactly the cycle where the first read's data is shown. It judges the cycle by three things:
- the first read's data is correct in that cycle;
- `ready` falls in the next cycle;
- the second read returns its own word.

The memory model in the bench floats its data to a marker pattern until output-enable has been low for the address access count. A read window that is too short therefore shows up as wrong data.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WREC,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_of(input seq_state_e s);
        strobe_t r;
        r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (s)
            ST_WSET: r.cs_n = 1'b0;
            ST_WPUL: begin
                r.cs_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_READ: begin
                r.cs_n = 1'b0;
                r.oe_n = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_seq_cnt.sv
`timescale 1ns/1ps
module sram_seq_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int N_RD  = 2,
    parameter int N_AS  = 0,
    parameter int N_WP  = 2,
    parameter int N_REC = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    ready,
    output logic    accept,
    output logic    capture,
    output strobe_t strb
);
    localparam logic [CNT_W-1:0] L_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] L_AS  = (N_AS > 0) ? CNT_W'(N_AS - 1) : '0;
    localparam logic [CNT_W-1:0] L_WP  = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] L_REC = CNT_W'(N_REC - 1);

    seq_state_e       st, nxt;
    logic             load, zero;
    logic [CNT_W-1:0] lval;

    sram_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(lval), .zero(zero)
    );

    always_comb begin
        nxt     = st;
        load    = 1'b0;
        lval    = '0;
        accept  = 1'b0;
        capture = 1'b0;
        case (st)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                load   = 1'b1;
                if (!req_write) begin
                    nxt  = ST_READ;
                    lval = L_RD;
                end else if (N_AS > 0) begin
                    nxt  = ST_WSET;
                    lval = L_AS;
                end else begin
                    nxt  = ST_WPUL;
                    lval = L_WP;
                end
            end
            ST_WSET: if (zero) begin
                nxt  = ST_WPUL;
                load = 1'b1;
                lval = L_WP;
            end
            ST_WPUL: if (zero) begin
                nxt  = ST_WREC;
                load = 1'b1;
                lval = L_REC;
            end
            ST_WREC: if (zero) nxt = ST_IDLE;
            ST_READ: if (zero) begin
                nxt     = ST_IDLE;
                capture = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    assign ready = (st == ST_IDLE);
    assign strb  = strobes_of(st);

    // R6: the bus driver is off in the cycle before output-enable falls
    a_r6_release_before_oe: assert property (@(posedge clk) disable iff (rst)
        !strb.oe_n |-> !$past(strb.drive));

    // R8: once a request is taken the sequencer is busy
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    // R9: write and output enables never overlap
    a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!strb.we_n && !strb.oe_n));
endmodule

// File: rtl/sram_seq_dpath.sv
`timescale 1ns/1ps
module sram_seq_dpath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rd_data <= dq_in;
            rd_valid <= capture;
        end
    end

    // R10: read data strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 16,
    parameter int CNT_W         = 6,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC_NS       = 8,
    parameter int T_AA_NS       = 8,
    parameter int T_OE_NS       = 4,
    parameter int T_WC_NS       = 8,
    parameter int T_CW_NS       = 6,
    parameter int T_AS_NS       = 0,
    parameter int T_AW_NS       = 6,
    parameter int T_WP_NS       = 6,
    parameter int T_OW_NS       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int C_RC = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int C_AA = ns_to_cycles(T_AA_NS, CLK_PERIOD_NS);
    localparam int C_OE = ns_to_cycles(T_OE_NS, CLK_PERIOD_NS);
    localparam int C_WC = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int C_CW = ns_to_cycles(T_CW_NS, CLK_PERIOD_NS);
    localparam int C_AS = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
    localparam int C_AW = ns_to_cycles(T_AW_NS, CLK_PERIOD_NS);
    localparam int C_WP = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
    localparam int C_OW = ns_to_cycles(T_OW_NS, CLK_PERIOD_NS);

    localparam int N_RD  = imax(1, imax(C_RC, imax(C_AA, C_OE)));
    localparam int N_AS  = C_AS;
    localparam int N_WP  = imax(1, imax(C_WP, imax(C_CW - N_AS, C_AW - N_AS)));
    localparam int N_REC = imax(1, imax(C_OW, C_WC - N_AS - N_WP));

    logic    accept, capture;
    strobe_t strb;

    sram_seq_ctrl #(
        .CNT_W(CNT_W), .N_RD(N_RD), .N_AS(N_AS), .N_WP(N_WP), .N_REC(N_REC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .ready(ready), .accept(accept), .capture(capture), .strb(strb)
    );

    sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
        .addr_q(mem_addr), .wdata_q(mem_dq_out),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign mem_cs_n  = strb.cs_n;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_dq_oe = strb.drive;

    // R4: address and data hold steady across consecutive pulse cycles
    a_r4_hold_during_pulse: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R5: bus driven only inside a selected write pulse
    a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

    // R9: idle means deselected
    a_r9_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        ready |-> mem_cs_n);

    // R10: read data strobe only after a read window
    a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(mem_oe_n));
endmodule

// File: tb/sram_seq_tb.sv
`timescale 1ns/1ps
module sram_seq_tb;
    localparam int CLK_PERIOD = 5;
    localparam int EXP_RD  = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_AA  = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP  = (6 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_REC = 1;
    localparam logic [15:0] FLOAT_PAT = 16'hF1F1;

    localparam int VEC_N = 10;
    // {write, addr, data}
    localparam logic [24:0] VEC [VEC_N] = '{
        {1'b1, 8'h10, 16'hA5A5}, {1'b1, 8'h11, 16'h5A5A},
        {1'b0, 8'h10, 16'h0000}, {1'b0, 8'h11, 16'h0000},
        {1'b1, 8'h10, 16'hFFFF}, {1'b0, 8'h10, 16'h0000},
        {1'b1, 8'hFF, 16'h0001}, {1'b0, 8'hFF, 16'h0000},
        {1'b1, 8'h00, 16'h8000}, {1'b0, 8'h00, 16'h0000}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] rd_data, mem_dq_out, mem_dq_in;
    logic [7:0]  mem_addr;

    logic [15:0] model_mem [256];
    logic [15:0] shadow    [256];
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    int          we_run = 0, rd_run = 0;
    logic [7:0]  pul_addr;
    logic [15:0] pul_data;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    sram_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    assign mem_dq_in = (rd_run >= EXP_AA) ? model_mem[mem_addr] : FLOAT_PAT;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and protocol monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            we_run = 0;
            rd_run = 0;
        end else begin
            chk(!(!mem_we_n && !mem_oe_n), "R9 we/oe overlap",
                {30'd0, mem_we_n, mem_oe_n}, 32'h3);
            chk(!mem_dq_oe || (!mem_we_n && !mem_cs_n), "R5 drive outside pulse",
                {31'd0, mem_dq_oe}, 32'h0);
            if (!mem_cs_n && !mem_we_n) begin
                if (we_run > 0)
                    chk(mem_addr == pul_addr && mem_dq_out == pul_data, "R4 hold in pulse",
                        {8'd0, mem_addr, mem_dq_out}, {8'd0, pul_addr, pul_data});
                pul_addr = mem_addr;
                pul_data = mem_dq_out;
                model_mem[mem_addr] = mem_dq_out;
                we_run++;
            end else if (we_run > 0) begin
                chk(we_run == EXP_WP, "R2 R4 pulse length", we_run, EXP_WP);
                chk(mem_cs_n && mem_oe_n && !mem_dq_oe, "R6 recovery after pulse",
                    {29'd0, mem_cs_n, mem_oe_n, mem_dq_oe}, 32'h6);
                we_run = 0;
            end
            if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_run++;
            else if (rd_run > 0) begin
                chk(rd_run == EXP_RD, "R2 R7 read window", rd_run, EXP_RD);
                rd_run = 0;
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        int  k;
        bit  saw;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ready, "R8 busy after write accept", {31'd0, ready}, 0);
        k = 1; saw = 0;
        while (!ready) begin
            @(negedge clk);
            k++;
            if (rd_valid) saw = 1;
        end
        chk(k == EXP_WP + EXP_REC + 1, "R7 write occupancy", k, EXP_WP + EXP_REC + 1);
        chk(!saw, "R10 no valid on write", {31'd0, saw}, 0);
        shadow[a] = d;
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        int k;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!rd_valid) begin
            @(negedge clk);
            k++;
        end
        chk(k == EXP_RD + 1, "R3 read latency", k, EXP_RD + 1);
        chk(rd_data == shadow[a], tag, {16'd0, rd_data}, {16'd0, shadow[a]});
        @(negedge clk);
        chk(!rd_valid, "R10 valid is one cycle", {31'd0, rd_valid}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = '0;
            shadow[i]    = '0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
            "R1 reset state",
            {26'd0, ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 32'h3C);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 first cycle after reset",
            {27'd0, ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h1E);
        repeat (3) begin
            @(negedge clk);
            chk(ready && mem_cs_n, "R9 idle deselected", {30'd0, ready, mem_cs_n}, 32'h3);
        end

        // table of vectors
        for (int i = 0; i < VEC_N; i++) begin
            if (VEC[i][24]) do_write(VEC[i][23:16], VEC[i][15:0]);
            else            do_read(VEC[i][23:16], "R3 R4 table readback");
        end

        // R8: request raised while busy is ignored
        do_write(8'h20, 16'h1111);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 16'h2222;
        @(negedge clk);
        req_addr = 8'h21; req_wdata = 16'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ready, "R8 busy while request held", {31'd0, ready}, 0);
        while (!ready) @(negedge clk);
        shadow[8'h20] = 16'h2222;
        do_read(8'h20, "R8 busy request did not alter write");
        do_read(8'h21, "R8 busy request did not write memory");

        // hand-off: new read taken in the cycle carrying rd_valid
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rd_valid) @(negedge clk);
        chk(rd_data == shadow[8'h11], "R3 first read in hand-off", rd_data, shadow[8'h11]);
        chk(ready, "R8 ready together with rd_valid", {31'd0, ready}, 1);
        req_valid = 1'b1; req_addr = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ready, "R8 hand-off request taken", {31'd0, ready}, 0);
        chk(!rd_valid, "R10 pulse ended in hand-off", {31'd0, rd_valid}, 0);
        while (!rd_valid) @(negedge clk);
        chk(rd_data == shadow[8'hFF], "R3 second read in hand-off", rd_data, shadow[8'hFF]);

        // R1: reset in the middle of a write pulse
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hEE; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_we_n && mem_dq_oe, "R4 pulse started", {30'd0, mem_we_n, mem_dq_oe}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready,
            "R1 reset during write",
            {27'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 32'h1D);
        rst = 1'b0;
        @(negedge clk);
        do_read(8'h10, "R3 read after mid-write reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule